// File: doc/BRIEF.md
# Multi-level Page Table Range Walker

This block enumerates every leaf mapping that a radix page-table hierarchy holds over a requested IO virtual address window [start, end). A host pulses `go_i` with a root table base, a table depth, an address-width code, the window bounds and an unmap-report flag. The walker then reads 64-bit table entries over a request/response memory port. For each leaf it meets, it emits a record that carries the page-aligned IOVA, the output address, the page mask and the accumulated read/write permission.

Descent is iterative. A per-level stack holds, for each level, the table base, the sub-window end and the permissions inherited from the parent. The controller has seven states. IDLE takes `go_i` and moves to CHECK, or to DONE when the start address is out of range. CHECK compares the current IOVA with the end bound of the current level. It moves to REQ when entries remain, stays in CHECK while it pops one level per cycle, and moves to DONE once the top level is exhausted. REQ holds a read until it is accepted and then moves to WAIT. WAIT takes the response and moves to EVAL. EVAL either moves to EMIT for a reportable leaf, or returns to CHECK after a skip or a push. EMIT holds a record until it is accepted and then returns to CHECK. DONE lasts one cycle and returns to IDLE.

Entries use these bits: bit 0 grants read, bit 1 grants write, bit 7 marks a large page, and bits [MGAW-1:12] hold the next-table or output address. MGAW defaults to 39.

Top module: `ptw_range_walker`

## Requirements
- R1: The guest address width is 30 + 9·`aw_i`. The range limit is 2^min(width, MGAW), with MGAW = 39.
- R2: If `start_i` is at or above the limit, the block issues no read and no record. It raises `fault_o` together with `done_o` in the cycle after `go_i`.
- R3: If `end_i` is at or above the limit, the walk uses the limit as its end.
- R4: At level L the page shift is 12 + 9·(L−1). The entry read is at table base + 8·IOVA[shift+8:shift]. After each entry, the IOVA advances to (IOVA aligned down to the level page) + the level page size.
- R5: The block skips an entry without a record in any of these cases: the response carries an error, the entry reads as all ones, any of bits [63:39] is set, bit 7 is set at level 4, or a large leaf at level 2 or 3 has a nonzero bit in [shift−1:12].
- R6: The walk starts at the top level with read and write both granted. The effective read is the parent's read AND bit 0, and the effective write is the parent's write AND bit 1.
- R7: A non-leaf entry with neither effective permission is skipped. Otherwise the walk descends into the table at bits [38:12] over [IOVA, min(next IOVA, current end)).
- R8: A leaf is any level-1 entry, or a level-2 or level-3 entry with bit 7 set. Its record carries the IOVA aligned to the level page, an output address of bits [38:12]·4096, a mask of page size − 1 and the effective permissions. Records come out in ascending IOVA order.
- R9: A leaf with neither effective permission produces a record only when `unmap_i` was set at `go_i`.
- R10: While `rec_valid_o` is high and `rec_ready_i` is low, the record fields hold steady and the walk does not advance.
- R11: After the last entry of the top level, `done_o` pulses for exactly one cycle. After reset, `done_o`, `rec_valid_o` and `req_valid_o` are low.
- R12: While `req_valid_o` is high and `req_ready_i` is low, the request stays asserted with a stable address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Starts a walk; sampled only while idle |
| root_i | input | ADDR_W | Base of the top-level table |
| levels_i | input | 3 | Number of table levels (1 to 4) |
| aw_i | input | 3 | Address-width code |
| start_i | input | ADDR_W | First IOVA of the window |
| end_i | input | ADDR_W | Exclusive end of the window |
| unmap_i | input | 1 | Also report leaves that have no permission |
| req_valid_o | output | 1 | Entry read request valid |
| req_ready_i | input | 1 | Memory accepts the request |
| req_addr_o | output | ADDR_W | Byte address of the entry |
| rsp_valid_i | input | 1 | Read response valid |
| rsp_data_i | input | 64 | Entry value |
| rsp_err_i | input | 1 | Read failed |
| rec_valid_o | output | 1 | Mapping record valid |
| rec_ready_i | input | 1 | Consumer accepts the record |
| rec_iova_o | output | ADDR_W | Page-aligned IOVA |
| rec_addr_o | output | ADDR_W | Output address |
| rec_mask_o | output | ADDR_W | Page size minus one |
| rec_rd_o | output | 1 | Effective read permission |
| rec_wr_o | output | 1 | Effective write permission |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| fault_o | output | 1 | Start beyond range, valid with done_o |

## Verification
The hard coincidence is the final record's handshake landing on the same path as the stack unwinding several levels into the done pulse. A window that ends exactly on the last page of a level-1 table, with the record consumer throttled, provokes it. The bench checks three things there: that exactly one record arrives, that `done_o` appears only after that record was accepted, and that `done_o` lasts one cycle. A second pairing is the end clamp and the range fault, which are decided in the same cycle at `go_i`. It is exercised with start just below and at the limit under several width codes. The bench's reference model translates page by page and is compared with each record as it is accepted.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int ENT_W   = 64;
    localparam int PAGE_SH = 12;
    localparam int IDX_W   = 9;
    localparam int LVL_W   = 3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_REQ,
        S_WAIT,
        S_EVAL,
        S_EMIT,
        S_DONE
    } walk_state_e;
endpackage

// File: rtl/ptw_limit.sv
module ptw_limit #(
    parameter int ADDR_W = 48,
    parameter int MGAW   = 39
) (
    input  logic [2:0]        aw_i,
    input  logic [ADDR_W-1:0] start_i,
    input  logic [ADDR_W-1:0] end_i,
    output logic [ADDR_W-1:0] end_o,
    output logic              beyond_o
);
    logic [6:0]        gaw;
    logic [6:0]        eff;
    logic [ADDR_W-1:0] lim;

    always_comb begin
        gaw      = 7'd30 + 7'd9 * {4'd0, aw_i};
        eff      = (gaw > 7'(MGAW)) ? 7'(MGAW) : gaw;
        lim      = ADDR_W'(1) << eff;
        beyond_o = (start_i >= lim);
        end_o    = (end_i >= lim) ? lim : end_i;
    end
endmodule

// File: rtl/ptw_level_geom.sv
module ptw_level_geom
    import ptw_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic [LVL_W-1:0]  lvl_i,
    input  logic [ADDR_W-1:0] iova_i,
    output logic [ADDR_W-1:0] lo_o,
    output logic [ADDR_W-1:0] align_o,
    output logic [ADDR_W-1:0] next_o,
    output logic [IDX_W-1:0]  idx_o
);
    logic [5:0]        sh;
    logic [ADDR_W-1:0] size;

    always_comb begin
        sh      = 6'(PAGE_SH) + 6'(IDX_W) * (6'(lvl_i) - 6'd1);
        size    = ADDR_W'(1) << sh;
        lo_o    = size - ADDR_W'(1);
        align_o = iova_i & ~lo_o;
        next_o  = align_o + size;
        idx_o   = IDX_W'(iova_i >> sh);
    end
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode
    import ptw_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int MGAW   = 39
) (
    input  logic [ENT_W-1:0]  ent_i,
    input  logic              err_i,
    input  logic [LVL_W-1:0]  lvl_i,
    input  logic [ADDR_W-1:0] lo_i,
    input  logic              prd_i,
    input  logic              pwr_i,
    output logic              skip_o,
    output logic              leaf_o,
    output logic              rd_o,
    output logic              wr_o,
    output logic [ADDR_W-1:0] addr_o
);
    logic ps;
    logic lvl_one;
    logic hi_rsvd;
    logic ps_rsvd;
    logic big_rsvd;

    always_comb begin
        ps       = ent_i[7];
        lvl_one  = (lvl_i == LVL_W'(1));
        leaf_o   = lvl_one || (ps && (lvl_i == LVL_W'(2) || lvl_i == LVL_W'(3)));
        hi_rsvd  = |ent_i[ENT_W-1:MGAW];
        ps_rsvd  = ps && (lvl_i > LVL_W'(3));
        big_rsvd = leaf_o && !lvl_one &&
                   (|(ent_i[ADDR_W-1:0] & lo_i & ~ADDR_W'(12'hfff)));
        skip_o   = err_i || (&ent_i) || hi_rsvd || ps_rsvd || big_rsvd;
        rd_o     = prd_i && ent_i[0];
        wr_o     = pwr_i && ent_i[1];
        addr_o   = '0;
        addr_o[MGAW-1:PAGE_SH] = ent_i[MGAW-1:PAGE_SH];
    end
endmodule

// File: rtl/ptw_range_walker.sv
module ptw_range_walker
    import ptw_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int MGAW   = 39
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [ADDR_W-1:0] root_i,
    input  logic [LVL_W-1:0]  levels_i,
    input  logic [2:0]        aw_i,
    input  logic [ADDR_W-1:0] start_i,
    input  logic [ADDR_W-1:0] end_i,
    input  logic              unmap_i,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic [ADDR_W-1:0] req_addr_o,
    input  logic              rsp_valid_i,
    input  logic [ENT_W-1:0]  rsp_data_i,
    input  logic              rsp_err_i,
    output logic              rec_valid_o,
    input  logic              rec_ready_i,
    output logic [ADDR_W-1:0] rec_iova_o,
    output logic [ADDR_W-1:0] rec_addr_o,
    output logic [ADDR_W-1:0] rec_mask_o,
    output logic              rec_rd_o,
    output logic              rec_wr_o,
    output logic              done_o,
    output logic              fault_o
);
    localparam int STK_N = 1 << LVL_W;

    walk_state_e       state_q, state_d;
    logic [LVL_W-1:0]  lvl_q, top_q;
    logic [ADDR_W-1:0] iova_q;
    logic [ENT_W-1:0]  ent_q;
    logic              err_q, unmap_q, fault_q;

    logic [ADDR_W-1:0] stk_base [STK_N];
    logic [ADDR_W-1:0] stk_end  [STK_N];
    logic              stk_rd   [STK_N];
    logic              stk_wr   [STK_N];

    logic [ADDR_W-1:0] end_clamp;
    logic              beyond;
    logic [ADDR_W-1:0] lo, align, nxt, tbl_addr, sub_end;
    logic [IDX_W-1:0]  idx;
    logic              skip, leaf, eff_rd, eff_wr;
    logic              at_end, descend, emit;

    ptw_limit #(.ADDR_W(ADDR_W), .MGAW(MGAW)) u_limit (
        .aw_i     (aw_i),
        .start_i  (start_i),
        .end_i    (end_i),
        .end_o    (end_clamp),
        .beyond_o (beyond)
    );

    ptw_level_geom #(.ADDR_W(ADDR_W)) u_geom (
        .lvl_i   (lvl_q),
        .iova_i  (iova_q),
        .lo_o    (lo),
        .align_o (align),
        .next_o  (nxt),
        .idx_o   (idx)
    );

    ptw_entry_decode #(.ADDR_W(ADDR_W), .MGAW(MGAW)) u_dec (
        .ent_i  (ent_q),
        .err_i  (err_q),
        .lvl_i  (lvl_q),
        .lo_i   (lo),
        .prd_i  (stk_rd[lvl_q]),
        .pwr_i  (stk_wr[lvl_q]),
        .skip_o (skip),
        .leaf_o (leaf),
        .rd_o   (eff_rd),
        .wr_o   (eff_wr),
        .addr_o (tbl_addr)
    );

    always_comb begin
        at_end  = (iova_q >= stk_end[lvl_q]);
        sub_end = (nxt < stk_end[lvl_q]) ? nxt : stk_end[lvl_q];
        descend = !skip && !leaf && (eff_rd || eff_wr);
        emit    = !skip && leaf && (eff_rd || eff_wr || unmap_q);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (go_i) state_d = beyond ? S_DONE : S_CHECK;
            S_CHECK: begin
                if (!at_end)             state_d = S_REQ;
                else if (lvl_q == top_q) state_d = S_DONE;
            end
            S_REQ:   if (req_ready_i) state_d = S_WAIT;
            S_WAIT:  if (rsp_valid_i) state_d = S_EVAL;
            S_EVAL:  state_d = emit ? S_EMIT : S_CHECK;
            S_EMIT:  if (rec_ready_i) state_d = S_CHECK;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // walk datapath and level stack
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q   <= '0;
            top_q   <= '0;
            iova_q  <= '0;
            ent_q   <= '0;
            err_q   <= 1'b0;
            unmap_q <= 1'b0;
            fault_q <= 1'b0;
            for (int i = 0; i < STK_N; i++) begin
                stk_base[i] <= '0;
                stk_end[i]  <= '0;
                stk_rd[i]   <= 1'b0;
                stk_wr[i]   <= 1'b0;
            end
        end else begin
            case (state_q)
                S_IDLE: if (go_i) begin
                    fault_q            <= beyond;
                    unmap_q            <= unmap_i;
                    lvl_q              <= levels_i;
                    top_q              <= levels_i;
                    iova_q             <= start_i;
                    stk_base[levels_i] <= root_i;
                    stk_end[levels_i]  <= end_clamp;
                    stk_rd[levels_i]   <= 1'b1;
                    stk_wr[levels_i]   <= 1'b1;
                end
                S_CHECK: if (at_end && lvl_q != top_q) lvl_q <= lvl_q + LVL_W'(1);
                S_WAIT: if (rsp_valid_i) begin
                    ent_q <= rsp_data_i;
                    err_q <= rsp_err_i;
                end
                S_EVAL: begin
                    if (descend) begin
                        stk_base[lvl_q - LVL_W'(1)] <= tbl_addr;
                        stk_end[lvl_q - LVL_W'(1)]  <= sub_end;
                        stk_rd[lvl_q - LVL_W'(1)]   <= eff_rd;
                        stk_wr[lvl_q - LVL_W'(1)]   <= eff_wr;
                        lvl_q                       <= lvl_q - LVL_W'(1);
                    end else if (!emit) begin
                        iova_q <= nxt;
                    end
                end
                S_EMIT: if (rec_ready_i) iova_q <= nxt;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_valid_o = (state_q == S_REQ);
        req_addr_o  = stk_base[lvl_q] + ADDR_W'({idx, 3'b000});
        rec_valid_o = (state_q == S_EMIT);
        rec_iova_o  = align;
        rec_addr_o  = tbl_addr;
        rec_mask_o  = lo;
        rec_rd_o    = eff_rd;
        rec_wr_o    = eff_wr;
        done_o      = (state_q == S_DONE);
        fault_o     = (state_q == S_DONE) && fault_q;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o)); // R12
    AST_REC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid_o && !rec_ready_i |=> rec_valid_o && $stable(rec_iova_o) &&
        $stable(rec_addr_o) && $stable(rec_mask_o) && $stable(rec_rd_o) &&
        $stable(rec_wr_o)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R11
    AST_FAULT_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> $past(go_i)); // R2
    AST_REC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid_o |-> (rec_iova_o & rec_mask_o) == '0); // R8
    AST_UNMAP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid_o && !rec_rd_o && !rec_wr_o |-> unmap_q); // R9
endmodule

// File: tb/tb_ptw_range_walker.sv
`timescale 1ns/1ps
module tb_ptw_range_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go_i = 1'b0;
    logic [47:0] root_i = '0;
    logic [2:0]  levels_i = '0;
    logic [2:0]  aw_i = '0;
    logic [47:0] start_i = '0;
    logic [47:0] end_i = '0;
    logic        unmap_i = 1'b0;
    logic        req_valid_o;
    logic        req_ready_i;
    logic [47:0] req_addr_o;
    logic        rsp_valid_i;
    logic [63:0] rsp_data_i;
    logic        rsp_err_i;
    logic        rec_valid_o;
    logic        rec_ready_i;
    logic [47:0] rec_iova_o, rec_addr_o, rec_mask_o;
    logic        rec_rd_o, rec_wr_o;
    logic        done_o, fault_o;

    ptw_range_walker dut (
        .clk(clk), .rst_n(rst_n), .go_i(go_i), .root_i(root_i), .levels_i(levels_i),
        .aw_i(aw_i), .start_i(start_i), .end_i(end_i), .unmap_i(unmap_i),
        .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_addr_o(req_addr_o),
        .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i), .rsp_err_i(rsp_err_i),
        .rec_valid_o(rec_valid_o), .rec_ready_i(rec_ready_i), .rec_iova_o(rec_iova_o),
        .rec_addr_o(rec_addr_o), .rec_mask_o(rec_mask_o), .rec_rd_o(rec_rd_o),
        .rec_wr_o(rec_wr_o), .done_o(done_o), .fault_o(fault_o)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int req_bp = 0;
    int rec_bp = 0;
    int reads_run = 0;
    int recs_run = 0;

    always @(posedge clk) cyc <= cyc + 1;

    logic [63:0] mem   [bit [63:0]];
    bit          errm  [bit [63:0]];
    bit          seen  [bit [63:0]];

    logic [47:0] q_iova[$], q_addr[$], q_mask[$];
    bit          q_rd[$], q_wr[$];

    logic [47:0] cfg_root;
    int          cfg_levels;
    bit          cfg_unmap;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] rd_mem(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    // page-by-page reference translation: where does the walk stop for this IOVA
    task automatic model_lookup(input logic [47:0] iova, output int tl, output bit emit,
                                output logic [47:0] oa, output bit orr, output bit ow);
        logic [47:0] base;
        bit r, w, stop;
        base = cfg_root; r = 1; w = 1; stop = 0;
        tl = 1; emit = 0; oa = '0; orr = 0; ow = 0;
        for (int lv = cfg_levels; lv >= 1; lv--) begin
            int sh;
            logic [63:0] a, e;
            bit lf, bad, nr, nw;
            if (!stop) begin
                sh = 12 + 9 * (lv - 1);
                a = {16'd0, base} + ((({16'd0, iova}) >> sh) & 64'h1ff) * 8;
                seen[a] = 1;
                e = rd_mem(a);
                lf = (lv == 1) || (e[7] && (lv == 2 || lv == 3));
                bad = errm.exists(a) || (&e) || (e[63:39] != 0) || (lv == 4 && e[7]);
                if (lf && lv > 1 && (((e >> 12) & ((64'd1 << (sh - 12)) - 1)) != 0)) bad = 1;
                nr = r & e[0];
                nw = w & e[1];
                tl = lv;
                if (bad) stop = 1;
                else if (lf) begin
                    emit = nr | nw | cfg_unmap;
                    oa = {9'd0, e[38:12], 12'h000};
                    orr = nr; ow = nw; stop = 1;
                end else if (!(nr | nw)) stop = 1;
                else begin
                    base = {9'd0, e[38:12], 12'h000};
                    r = nr; w = nw;
                end
            end
        end
    endtask

    // memory responder: one-cycle latency, optional request backpressure
    bit          pend = 0;
    logic [47:0] paddr;
    bit          req_hold = 0;
    logic [47:0] req_hold_addr;
    initial begin
        req_ready_i = 1'b0; rsp_valid_i = 1'b0; rsp_data_i = '0; rsp_err_i = 1'b0;
        forever begin
            @(negedge clk);
            if (req_hold) check(req_valid_o && req_addr_o == req_hold_addr, "R12",
                                "request held", longint'(req_addr_o), longint'(req_hold_addr));
            rsp_valid_i = 1'b0; rsp_err_i = 1'b0;
            if (pend) begin
                rsp_valid_i = 1'b1;
                rsp_data_i  = rd_mem({16'd0, paddr});
                rsp_err_i   = errm.exists({16'd0, paddr});
                pend = 0;
            end
            req_ready_i = (req_bp == 0) ? 1'b1 : ((cyc % req_bp) == 1);
            req_hold = req_valid_o && !req_ready_i;
            req_hold_addr = req_addr_o;
            if (req_valid_o && req_ready_i) begin
                pend = 1; paddr = req_addr_o; reads_run++;
                if (!seen.exists({16'd0, req_addr_o}))
                    check(0, "R4", "unexpected entry address", longint'(req_addr_o), 0);
            end
        end
    end

    // record sink with optional backpressure, compared against the model queue
    bit          rh = 0;
    logic [47:0] rh_iova, rh_addr, rh_mask;
    bit          rh_rd, rh_wr;
    initial begin
        rec_ready_i = 1'b0;
        forever begin
            @(negedge clk);
            if (rh) check(rec_valid_o && rec_iova_o == rh_iova && rec_addr_o == rh_addr &&
                          rec_mask_o == rh_mask && rec_rd_o == rh_rd && rec_wr_o == rh_wr,
                          "R10", "record held", longint'(rec_iova_o), longint'(rh_iova));
            rec_ready_i = (rec_bp == 0) ? 1'b1 : ((cyc % rec_bp) == 0);
            rh = rec_valid_o && !rec_ready_i;
            rh_iova = rec_iova_o; rh_addr = rec_addr_o; rh_mask = rec_mask_o;
            rh_rd = rec_rd_o; rh_wr = rec_wr_o;
            if (rec_valid_o && rec_ready_i) begin
                recs_run++;
                if (q_iova.size() == 0) check(0, "R8", "extra record", longint'(rec_iova_o), 0);
                else begin
                    check(rec_iova_o == q_iova[0], "R8", "iova", longint'(rec_iova_o), longint'(q_iova[0]));
                    check(rec_addr_o == q_addr[0], "R8", "addr", longint'(rec_addr_o), longint'(q_addr[0]));
                    check(rec_mask_o == q_mask[0], "R4", "mask", longint'(rec_mask_o), longint'(q_mask[0]));
                    check(rec_rd_o == q_rd[0] && rec_wr_o == q_wr[0], "R6", "perm",
                          longint'({rec_rd_o, rec_wr_o}), longint'({q_rd[0], q_wr[0]}));
                    void'(q_iova.pop_front()); void'(q_addr.pop_front()); void'(q_mask.pop_front());
                    void'(q_rd.pop_front()); void'(q_wr.pop_front());
                end
            end
        end
    end

    task automatic run_walk(input string tag, input logic [47:0] root, input int lv,
                            input int aw, input logic [47:0] st, input logic [47:0] en,
                            input bit um, input int rbp, input int obp);
        logic [47:0] lim, endc, iova, sz, al, oa;
        int gw, tl, waited, nexp;
        bit emit, orr, ow, exp_fault;
        cfg_root = root; cfg_levels = lv; cfg_unmap = um;
        seen.delete();
        gw = 30 + 9 * aw; if (gw > 39) gw = 39;
        lim = 48'd1 << gw;
        exp_fault = (st >= lim);
        endc = (en >= lim) ? lim : en;
        if (!exp_fault) begin
            iova = st;
            while (iova < endc) begin
                model_lookup(iova, tl, emit, oa, orr, ow);
                sz = 48'd1 << (12 + 9 * (tl - 1));
                al = iova & ~(sz - 1);
                if (emit) begin
                    q_iova.push_back(al); q_addr.push_back(oa); q_mask.push_back(sz - 1);
                    q_rd.push_back(orr); q_wr.push_back(ow);
                end
                iova = al + sz;
            end
        end
        nexp = q_iova.size();
        req_bp = rbp; rec_bp = obp; reads_run = 0; recs_run = 0;
        @(negedge clk);
        root_i = root; levels_i = 3'(lv); aw_i = 3'(aw); start_i = st; end_i = en;
        unmap_i = um; go_i = 1'b1;
        @(negedge clk);
        go_i = 1'b0;
        waited = 0;
        while (!done_o && waited < 60000) begin
            @(negedge clk);
            waited++;
        end
        if (!done_o) begin
            check(0, "R11", {tag, " watchdog"}, waited, 0);
        end else begin
            check(fault_o == exp_fault, "R2", {tag, " fault"}, longint'(fault_o), longint'(exp_fault));
            check(recs_run == nexp, "R8", {tag, " record count"}, recs_run, nexp);
            if (exp_fault) check(reads_run == 0 && waited == 0, "R2", {tag, " no reads, immediate"},
                                 reads_run, 0);
            @(negedge clk);
            check(!done_o, "R11", {tag, " done single pulse"}, longint'(done_o), 0);
        end
        q_iova.delete(); q_addr.delete(); q_mask.delete(); q_rd.delete(); q_wr.delete();
    endtask

    localparam logic [63:0] T3  = 64'h10000;
    localparam logic [63:0] T2A = 64'h11000;
    localparam logic [63:0] T1A = 64'h12000;
    localparam logic [63:0] T1B = 64'h13000;
    localparam logic [63:0] T4  = 64'h20000;

    initial begin
        // top level (level 3)
        mem[T3 + 0]  = T2A | 64'h3;
        mem[T3 + 8]  = 64'h8000_0000 | 64'h83;              // R8 1 GiB leaf
        mem[T3 + 16] = (64'd1 << 50) | 64'h14000 | 64'h3;   // R5 high reserved
        mem[T3 + 24] = 64'h15000;                           // R7 no permission
        mem[T3 + 32] = '1;                                  // R5 all ones
        mem[T3 + 40] = 64'h16000 | 64'h3;  errm[T3 + 40] = 1; // R5 error
        mem[64'h16000] = 64'h9000 | 64'h3;
        // level 2
        mem[T2A + 0]  = T1A | 64'h1;                        // read-only subtree
        mem[T2A + 8]  = 64'h4020_0000 | 64'h82;             // write-only 2 MiB
        mem[T2A + 16] = 64'h4040_1000 | 64'h83;             // large-page reserved bit
        mem[T2A + 24] = T1B | 64'h3;
        // level 1
        mem[T1A + 0]  = 64'hA0000 | 64'h3;
        mem[T1A + 8]  = 64'hA1000 | 64'h2;                  // R9 no effective perm
        mem[T1A + 40] = 64'hA5000 | 64'h3;
        mem[T1B + 0]  = 64'hB0000 | 64'h3;
        mem[T1B + 511 * 8] = 64'hBF000 | 64'h1;
        mem[T4 + 0]   = T3 | 64'h3;                         // level-4 root

        repeat (3) @(negedge clk);
        check(!done_o && !rec_valid_o && !req_valid_o, "R11", "reset outputs",
              longint'({done_o, rec_valid_o, req_valid_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!req_valid_o && !rec_valid_o, "R12", "idle after reset",
              longint'({req_valid_o, rec_valid_o}), 0);

        run_walk("R3 full clamp", T3[47:0], 3, 1, 48'd0, 48'hFFFF_FFFF_FFFF, 0, 0, 0);
        run_walk("R9 unmap bp", T3[47:0], 3, 1, 48'd0, 48'hFFFF_FFFF_FFFF, 1, 3, 3);
        run_walk("R4 partial", T3[47:0], 3, 1, 48'h1800, 48'h20_3000, 1, 2, 0);
        run_walk("R2 fault", T3[47:0], 3, 1, 48'h80_0000_0000, 48'h90_0000_0000, 0, 0, 0);
        run_walk("R1 aw0", T3[47:0], 3, 0, 48'd0, 48'hFFFF_FFFF_FFFF, 0, 0, 2);
        run_walk("R1 aw0 fault", T3[47:0], 3, 0, 48'h4000_0000, 48'h5000_0000, 0, 0, 0);
        run_walk("R1 aw2 fault", T3[47:0], 3, 2, 48'h80_0000_0000, 48'h80_0000_1000, 0, 0, 0);
        run_walk("R11 last page", T3[47:0], 3, 1, 48'h7F_F000, 48'h80_0000, 0, 3, 4);
        run_walk("R7 four level", T4[47:0], 4, 2, 48'd0, 48'h80_0000_0000, 0, 0, 0);
        run_walk("R5 skip window", T3[47:0], 3, 1, 48'h8000_0000, 48'h1_8000_0000, 1, 0, 0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule